// File: doc/BRIEF.md
# Calendar Timekeeping Counter Chain

This block keeps wall-clock time and the calendar date inside a larger chip. A digital enable that pulses at 32.768 kHz stands in for a crystal. A 15-bit prescaler turns those pulses into a one-second tick. Each tick advances a chain of packed-BCD counters for seconds, minutes, hours, day of month, month, weekday, two-digit year and century. The length of each month is applied automatically, and February gets its extra day in leap years, through the year 2099.

Host logic sets and reads the time through a small register port. The write side is a single-cycle strobe with an address and a data byte. The read side returns the addressed byte one cycle later. A control byte holds a lock bit that freezes every other register against writes. Writing the seconds register restarts the prescaler, so the following second is a full one.

Top module: `rtc_calendar_top`

## Requirements
- R1: `sec_tick` pulses for one cycle once every 2^PRESCALE_W cycles with `tb_en` high. Each such tick advances the seconds register by one.
- R2: Every time register is packed BCD. Seconds and minutes count 00..59 and wrap to 00, carrying into the next field. Hours count 00..23 and wrap to 00, carrying into the day.
- R3: On a day carry, the date wraps to 01 after the last day of its month. Months 04, 06, 09 and 11 have 30 days, month 02 has 28 or 29, and all other months have 31.
- R4: Month 02 has 29 days when the BCD year value is divisible by 4, which includes years 00 and 12.
- R5: On a day carry, the weekday counts 1..7 and wraps from 7 to 1. Month wraps from 12 to 01 and carries into the year. Year wraps from 99 to 00 and increments the BCD century.
- R6: When control bit 7 is set, writes to every address other than the control address leave the register file unchanged. The control register itself stays writable.
- R7: An accepted write to the seconds register clears the prescaler and any pending tick. The next tick then comes after exactly 2^PRESCALE_W further enable cycles.
- R8: When an accepted write lands in the same cycle as a tick, the tick is discarded. The written register takes the written value and all other registers hold.
- R9: The register map is: 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 weekday, 6 year, 7 control, 8 century. `rd_data` shows the register at `rd_addr` one cycle later, and unmapped addresses read 00.
- R10: After reset the registers read 00:00:00, date 01, month 01, weekday 1, year 00, control 00 and century 20.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tb_en | input | 1 | Timebase enable, one pulse per 32.768 kHz period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 8 | Write data (BCD for time registers) |
| rd_addr | input | 4 | Read address |
| rd_data | output | 8 | Registered read data |
| sec_tick | output | 1 | One-cycle pulse at each one-second tick |

## Verification
The bench builds the block with PRESCALE_W = 3, so one second takes eight enable cycles. This makes every rollover, from seconds through century, reachable in a few dozen cycles. The bench loads the time just before each boundary: end of day, 30-day and 31-day months, February in leap and common years, and the end of the century. It then lets one or two ticks run. The narrow prescaler also lets the bench place a write exactly on the tick cycle and count the enables between a seconds write and the next tick.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef logic [7:0] bcd8_t;

  localparam int unsigned REG_AW = 4;

  localparam logic [REG_AW-1:0] A_SEC  = 4'd0;
  localparam logic [REG_AW-1:0] A_MIN  = 4'd1;
  localparam logic [REG_AW-1:0] A_HOUR = 4'd2;
  localparam logic [REG_AW-1:0] A_DATE = 4'd3;
  localparam logic [REG_AW-1:0] A_MON  = 4'd4;
  localparam logic [REG_AW-1:0] A_WDAY = 4'd5;
  localparam logic [REG_AW-1:0] A_YEAR = 4'd6;
  localparam logic [REG_AW-1:0] A_CTRL = 4'd7;
  localparam logic [REG_AW-1:0] A_CENT = 4'd8;

  localparam int unsigned LOCK_BIT = 7;

  typedef struct packed {
    bcd8_t sec;
    bcd8_t min;
    bcd8_t hour;
    bcd8_t date;
    bcd8_t mon;
    bcd8_t wday;
    bcd8_t year;
    bcd8_t ctrl;
    bcd8_t cent;
  } rtc_regs_t;

  localparam rtc_regs_t REGS_RST = '{
    sec: 8'h00, min: 8'h00, hour: 8'h00, date: 8'h01, mon: 8'h01,
    wday: 8'h01, year: 8'h00, ctrl: 8'h00, cent: 8'h20};

  // Next packed-BCD value, 99 wraps to 00.
  function automatic bcd8_t bcd_inc(input bcd8_t v);
    bcd8_t r;
    if (v[3:0] == 4'd9) begin
      if (v[7:4] == 4'd9) r = 8'h00;
      else                r = {v[7:4] + 4'd1, 4'd0};
    end else begin
      r = {v[7:4], v[3:0] + 4'd1};
    end
    return r;
  endfunction

  function automatic logic is_leap(input bcd8_t y);
    logic [6:0] b;
    b = ({3'd0, y[7:4]} * 7'd10) + {3'd0, y[3:0]};
    return (b[1:0] == 2'b00);
  endfunction

  // Last day of a month as BCD.
  function automatic bcd8_t month_days(input bcd8_t m, input bcd8_t y);
    bcd8_t d;
    case (m)
      8'h02:                      d = is_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: d = 8'h30;
      default:                    d = 8'h31;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned PRESCALE_W = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic clr,
  output logic tick
);
  logic [PRESCALE_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (clr) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= en && (&cnt);
      if (en) cnt <= cnt + 1'b1;
    end
  end

  AST_CLR_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0) && !tick) else $error("prescaler not cleared"); // R7
  AST_TICK_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    tick |-> $past(en)) else $error("tick without enable"); // R1
endmodule

// File: rtl/rtc_reg_port.sv
module rtc_reg_port
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [REG_AW-1:0] rd_addr,
  input  rtc_regs_t         regs,
  output logic              wr_acc,
  output logic              sec_clr,
  output logic [7:0]        rd_data
);
  logic mapped;
  logic locked;

  always_comb begin
    mapped  = (wr_addr <= A_CENT);
    locked  = regs.ctrl[LOCK_BIT] && (wr_addr != A_CTRL);
    wr_acc  = wr_en && mapped && !locked;
    sec_clr = wr_acc && (wr_addr == A_SEC);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= 8'h00;
    end else begin
      case (rd_addr)
        A_SEC:   rd_data <= regs.sec;
        A_MIN:   rd_data <= regs.min;
        A_HOUR:  rd_data <= regs.hour;
        A_DATE:  rd_data <= regs.date;
        A_MON:   rd_data <= regs.mon;
        A_WDAY:  rd_data <= regs.wday;
        A_YEAR:  rd_data <= regs.year;
        A_CTRL:  rd_data <= regs.ctrl;
        A_CENT:  rd_data <= regs.cent;
        default: rd_data <= 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/rtc_calendar_chain.sv
module rtc_calendar_chain
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_acc,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output rtc_regs_t         regs
);
  logic  adv, c_min, c_hour, c_day, c_mon, c_year, c_cent;
  bcd8_t last_day;

  always_comb begin
    last_day = month_days(regs.mon, regs.year);
    adv      = tick && !wr_acc;
    c_min    = adv    && (regs.sec  == 8'h59);
    c_hour   = c_min  && (regs.min  == 8'h59);
    c_day    = c_hour && (regs.hour == 8'h23);
    c_mon    = c_day  && (regs.date == last_day);
    c_year   = c_mon  && (regs.mon  == 8'h12);
    c_cent   = c_year && (regs.year == 8'h99);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      regs <= REGS_RST;
    end else if (wr_acc) begin
      case (wr_addr)
        A_SEC:   regs.sec  <= wr_data;
        A_MIN:   regs.min  <= wr_data;
        A_HOUR:  regs.hour <= wr_data;
        A_DATE:  regs.date <= wr_data;
        A_MON:   regs.mon  <= wr_data;
        A_WDAY:  regs.wday <= wr_data;
        A_YEAR:  regs.year <= wr_data;
        A_CTRL:  regs.ctrl <= wr_data;
        A_CENT:  regs.cent <= wr_data;
        default: ;
      endcase
    end else begin
      if (adv)    regs.sec  <= (regs.sec  == 8'h59) ? 8'h00 : bcd_inc(regs.sec);
      if (c_min)  regs.min  <= (regs.min  == 8'h59) ? 8'h00 : bcd_inc(regs.min);
      if (c_hour) regs.hour <= (regs.hour == 8'h23) ? 8'h00 : bcd_inc(regs.hour);
      if (c_day) begin
        regs.date <= (regs.date == last_day) ? 8'h01 : bcd_inc(regs.date);
        regs.wday <= (regs.wday == 8'h07) ? 8'h01 : regs.wday + 8'h01;
      end
      if (c_mon)  regs.mon  <= (regs.mon  == 8'h12) ? 8'h01 : bcd_inc(regs.mon);
      if (c_year) regs.year <= bcd_inc(regs.year);
      if (c_cent) regs.cent <= bcd_inc(regs.cent);
    end
  end

  AST_SEC_BCD: assert property (@(posedge clk) disable iff (rst)
    $past(tick && !wr_acc) |-> (regs.sec <= 8'h59) && (regs.sec[3:0] <= 4'd9))
    else $error("seconds out of range"); // R2
  AST_SEC_STEP: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_acc) |=> regs.sec != $past(regs.sec)) else $error("tick lost"); // R1
  AST_DATE_FITS: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_acc) |=> (regs.date >= 8'h01) &&
      (regs.date <= month_days(regs.mon, regs.year))) else $error("date overflow"); // R3
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    (tick && wr_acc && wr_addr == A_MIN) |=>
      (regs.min == $past(wr_data)) && $stable(regs.sec)) else $error("tick beat write"); // R8
endmodule

// File: rtl/rtc_calendar_top.sv
module rtc_calendar_top
  import rtc_pkg::*;
#(
  parameter int unsigned PRESCALE_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tb_en,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              sec_tick
);
  rtc_regs_t regs;
  logic      wr_acc;
  logic      sec_clr;

  rtc_prescaler #(.PRESCALE_W(PRESCALE_W)) u_pre (
    .clk(clk), .rst(rst), .en(tb_en), .clr(sec_clr), .tick(sec_tick));

  rtc_reg_port u_port (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
    .regs(regs), .wr_acc(wr_acc), .sec_clr(sec_clr), .rd_data(rd_data));

  rtc_calendar_chain u_chain (
    .clk(clk), .rst(rst), .tick(sec_tick), .wr_acc(wr_acc),
    .wr_addr(wr_addr), .wr_data(wr_data), .regs(regs));

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && regs.ctrl[LOCK_BIT] && wr_addr == A_YEAR && !sec_tick) |=>
      regs.year == $past(regs.year)) else $error("locked write landed"); // R6
endmodule

// File: tb/sim_rtc_calendar_top.sv
module sim_rtc_calendar_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tb_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       sec_tick;

  rtc_calendar_top #(.PRESCALE_W(3)) u0 (
    .clk(clk), .rst(rst), .tb_en(tb_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .sec_tick(sec_tick));

  always #4 clk = ~clk;

  typedef struct {
    logic [3:0] a;
    logic [7:0] v;
    string      tag;
  } item_t;

  item_t q[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  int    ticks = 0;
  bit    req = 0;
  bit    armed = 0;
  bit    done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Monitor: compares the registered read data against the queue head.
  always @(negedge clk) begin
    if (sec_tick) ticks++;
    if (armed) begin
      item_t it;
      it = q.pop_front();
      chk($sformatf("%s addr %0d", it.tag, it.a), int'(rd_data), int'(it.v));
      armed = 0;
    end
    if (req) begin
      armed = 1;
      req = 0;
    end
  end

  // Driver tasks
  task automatic expect_reg(input logic [3:0] a, input logic [7:0] v, input string tag);
    rd_addr = a;
    q.push_back('{a: a, v: v, tag: tag});
    req = 1;
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      tb_en = 1;
      @(posedge clk); #1;
    end
    tb_en = 0;
  endtask

  task automatic settle();
    repeat (3) begin @(posedge clk); #1; end
  endtask

  task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    wr(4'd2, h); wr(4'd1, m); wr(4'd0, s);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int t0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(posedge clk); #1;

    // R10 reset values
    expect_reg(4'd0, 8'h00, "R10 sec");
    expect_reg(4'd3, 8'h01, "R10 date");
    expect_reg(4'd4, 8'h01, "R10 month");
    expect_reg(4'd5, 8'h01, "R10 wday");
    expect_reg(4'd7, 8'h00, "R10 ctrl");
    expect_reg(4'd8, 8'h20, "R10 century");

    // R1 / R7: seconds write restarts the prescaler
    wr(4'd0, 8'h10);
    t0 = ticks;
    pulses(7); settle();
    chk("R7 no tick before full second", ticks - t0, 0);
    expect_reg(4'd0, 8'h10, "R7 sec held");
    pulses(1); settle();
    chk("R1 one tick per period", ticks - t0, 1);
    expect_reg(4'd0, 8'h11, "R1 sec advanced");

    // R2 / R5: end of day rollover, weekday 7 -> 1
    wr(4'd4, 8'h06); wr(4'd3, 8'h15); wr(4'd5, 8'h07); wr(4'd6, 8'h23);
    set_time(8'h23, 8'h59, 8'h58);
    pulses(16); settle();
    expect_reg(4'd0, 8'h00, "R2 sec wrap");
    expect_reg(4'd1, 8'h00, "R2 min wrap");
    expect_reg(4'd2, 8'h00, "R2 hour wrap");
    expect_reg(4'd3, 8'h16, "R2 date carry");
    expect_reg(4'd5, 8'h01, "R5 wday wrap");

    // R3: 30-day month
    wr(4'd4, 8'h04); wr(4'd3, 8'h30);
    set_time(8'h23, 8'h59, 8'h59);
    pulses(8); settle();
    expect_reg(4'd3, 8'h01, "R3 april end date");
    expect_reg(4'd4, 8'h05, "R3 april end month");
    // R3: 31-day month keeps day 31
    wr(4'd3, 8'h30);
    set_time(8'h23, 8'h59, 8'h59);
    pulses(8); settle();
    expect_reg(4'd3, 8'h31, "R3 may 31");

    // R4: leap years 24, 12, 00; common year 23
    wr(4'd6, 8'h24); wr(4'd4, 8'h02); wr(4'd3, 8'h28);
    set_time(8'h23, 8'h59, 8'h59);
    pulses(8); settle();
    expect_reg(4'd3, 8'h29, "R4 leap 24 feb 29");
    set_time(8'h23, 8'h59, 8'h59);
    pulses(8); settle();
    expect_reg(4'd3, 8'h01, "R4 leap 24 after feb 29");
    expect_reg(4'd4, 8'h03, "R4 march");
    wr(4'd6, 8'h23); wr(4'd4, 8'h02); wr(4'd3, 8'h28);
    set_time(8'h23, 8'h59, 8'h59);
    pulses(8); settle();
    expect_reg(4'd3, 8'h01, "R3 common feb 28 end");
    wr(4'd6, 8'h12); wr(4'd4, 8'h02); wr(4'd3, 8'h28);
    set_time(8'h23, 8'h59, 8'h59);
    pulses(8); settle();
    expect_reg(4'd3, 8'h29, "R4 leap 12");
    wr(4'd6, 8'h00); wr(4'd3, 8'h28);
    set_time(8'h23, 8'h59, 8'h59);
    pulses(8); settle();
    expect_reg(4'd3, 8'h29, "R4 leap 00");

    // R5: year end and century
    wr(4'd4, 8'h12); wr(4'd6, 8'h99); wr(4'd3, 8'h31); wr(4'd8, 8'h20);
    set_time(8'h23, 8'h59, 8'h59);
    pulses(8); settle();
    expect_reg(4'd4, 8'h01, "R5 month wrap");
    expect_reg(4'd6, 8'h00, "R5 year wrap");
    expect_reg(4'd8, 8'h21, "R5 century inc");
    expect_reg(4'd3, 8'h01, "R5 date new year");

    // R6: lock bit
    wr(4'd1, 8'h10);
    wr(4'd7, 8'h80);
    wr(4'd1, 8'h33);
    wr(4'd6, 8'h55);
    expect_reg(4'd1, 8'h10, "R6 locked min");
    expect_reg(4'd6, 8'h00, "R6 locked year");
    expect_reg(4'd7, 8'h80, "R6 ctrl readback");
    wr(4'd7, 8'h00);
    wr(4'd1, 8'h33);
    expect_reg(4'd1, 8'h33, "R6 unlocked min");

    // R8: write on the tick cycle discards the tick
    wr(4'd0, 8'h05);
    t0 = ticks;
    pulses(8);
    wr(4'd1, 8'h44);
    settle();
    chk("R8 tick still pulsed", ticks - t0, 1);
    expect_reg(4'd0, 8'h05, "R8 sec held");
    expect_reg(4'd1, 8'h44, "R8 min written");
    pulses(8); settle();
    expect_reg(4'd0, 8'h06, "R8 next tick counts");

    // R9: unmapped address
    expect_reg(4'd15, 8'h00, "R9 unmapped");
    expect_reg(4'd9, 8'h00, "R9 unmapped 9");

    settle();
    chk("scoreboard drained", q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule